// File: doc/BRIEF.md
# Indirect-Addressed Codec Control Port

This block is the host-facing register port of an audio codec. A host with only a byte-wide data bus and a 2-bit address reaches every setting of the codec. Address 0 holds an index pointer and a few mode flags. Address 1 is a window onto one of sixteen 8-bit control registers, and the pointer chooses which one. Address 2 returns a status byte. Address 3 carries sample bytes: a host write lands in a playback register and a host read returns a separate capture register.

The conversion core sits next to the block and drives four kinds of one-cycle pulse. A capture pulse delivers a new capture byte and raises capture-ready. A playback pulse says the core has taken the playback byte and raises playback-ready. A flag tick refreshes the per-sample status flags. An interrupt event raises a sticky interrupt flag, but only when enabled. The stored control registers are driven out as a flat vector, along with the mode flags, the 16-bit base count and the interrupt line, so the core can decode them.

Host strobes are one cycle wide. Read data appears on the cycle after the read strobe and holds until the next read.

Top module: `codec_ctrl_port`

## Requirements
- R1: A one-cycle `host_rd` at address 0 (index), 1 (indexed data), 2 (status) or 3 (sample) places that port's pre-access value on `host_rdata` one cycle later. `host_rdata` keeps that value until the next read.
- R2: Writes and reads at address 1 go to the control register whose number is bits 3:0 of the most recent write to address 0.
- R3: A write to address 0 stores bit 6 and bit 5, which drive `cfg_mce` and `cfg_trd`. Reading address 0 returns those two bits in positions 6 and 5 and the index in bits 3:0. Bit 4 always reads 0.
- R4: Bit 7 of address 0 (`cfg_init`) is 1 from reset until the first write to address 0. From then on it is 0, whatever value is written.
- R5: Reserved bits of the control registers ignore writes and read 0. The writable masks, by register number, are: 0 and 1 = EF; 2 to 5 = 9F; 6 and 7 = BF; 8 = 7F; 9 = CF; 10 = C2; 12 = 0F; 13 = FD; 11, 14 and 15 = FF (hex).
- R6: A write to address 3 sets `play_byte` and leaves the capture byte unchanged. A read of address 3 returns the byte most recently delivered with `cap_valid`.
- R7: The status byte, from bit 7 down, is: capture upper/lower, capture left/right, capture ready, overrun, playback upper/lower, playback left/right, playback ready, interrupt.
- R8: `irq_event` sets the interrupt flag (`irq`, status bit 0) only while bit 1 of control register 10 is 1. Once set, the flag holds until the host writes any value to address 2. If an event and that write arrive in the same cycle, the flag stays set.
- R9: `cap_valid` sets capture ready, and a read at address 3 clears it. `play_take` sets playback ready, and a write at address 3 clears it. In both cases a set in the same cycle as the clear wins.
- R10: On `flag_tick`, `flag_vec[4]`, `[3]`, `[2]`, `[1]` and `[0]` replace status bits 7, 6, 4, 3 and 2. Between ticks those bits do not change.
- R11: `ctl_regs` carries control register n in bits 8n+7 to 8n. `base_count` is register 14 in the upper byte and register 15 in the lower byte.
- R12: After reset, every register, flag and output is 0, except that address 0 reads 80 (hex).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Direct port select |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | One-cycle read strobe |
| host_wr | input | 1 | One-cycle write strobe |
| host_rdata | output | 8 | Registered read byte |
| cap_valid | input | 1 | Core delivers a capture byte |
| cap_byte | input | 8 | Capture byte from the core |
| play_take | input | 1 | Core has consumed the playback byte |
| irq_event | input | 1 | Core interrupt event |
| flag_tick | input | 1 | Refresh strobe for per-sample flags |
| flag_vec | input | 5 | Per-sample flags from the core |
| play_byte | output | 8 | Playback byte to the core |
| irq | output | 1 | Sticky interrupt flag |
| cfg_init | output | 1 | Initialization flag |
| cfg_mce | output | 1 | Mode-change flag |
| cfg_trd | output | 1 | Transfer-request-disable flag |
| base_count | output | 16 | Base count from registers 14 and 15 |
| ctl_regs | output | 128 | All control registers, flattened |

## Verification
The in-RTL properties check the cycle-level rules on every clock:
- the interrupt flag only falls on a status write and only rises on an enabled event;
- the ready flags react to sample-port reads and writes, with set taking priority;
- the flags that are not sticky hold between ticks;
- INIT drops after an index write;
- the playback byte and the read data hold when no access touches them.

Only the bench's scenarios can show that the indexed window reaches the right register, that each register's reserved-bit mask is right, that the status bits sit in their stated positions, and that the capture and playback bytes stay apart at address 3.

// File: rtl/codec_port_pkg.sv
package codec_port_pkg;

    localparam int BYTE_W = 8;
    localparam int FLAG_W = 5;

    typedef enum logic [1:0] {
        PORT_INDEX  = 2'd0,
        PORT_IDATA  = 2'd1,
        PORT_STATUS = 2'd2,
        PORT_SAMPLE = 2'd3
    } port_e;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              crdy;
        logic              prdy;
        logic              intf;
    } stat_t;

    function automatic logic [BYTE_W-1:0] reg_wmask(input int unsigned n);
        logic [BYTE_W-1:0] m;
        case (n)
            0, 1:       m = 8'hEF;
            2, 3, 4, 5: m = 8'h9F;
            6, 7:       m = 8'hBF;
            8:          m = 8'h7F;
            9:          m = 8'hCF;
            10:         m = 8'hC2;
            12:         m = 8'h0F;
            13:         m = 8'hFD;
            default:    m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/codec_ireg_file.sv
module codec_ireg_file
    import codec_port_pkg::*;
#(
    parameter int NUM_REGS   = 16,
    parameter int IRQ_EN_REG = 10,
    parameter int IRQ_EN_BIT = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_index,
    input  logic                       wr_idata,
    input  logic [BYTE_W-1:0]          wdata,
    output logic [BYTE_W-1:0]          index_byte,
    output logic [BYTE_W-1:0]          cur_byte,
    output logic [NUM_REGS*BYTE_W-1:0] regs_flat,
    output logic                       irq_en,
    output logic                       init_o,
    output logic                       mce_o,
    output logic                       trd_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    typedef struct packed {
        logic                             init;
        logic                             mce;
        logic                             trd;
        logic [IDX_W-1:0]                 idx;
        logic [NUM_REGS-1:0][BYTE_W-1:0]  regs;
    } rf_t;

    rf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_index) begin
            s_d.init = 1'b0;
            s_d.mce  = wdata[6];
            s_d.trd  = wdata[5];
            s_d.idx  = wdata[IDX_W-1:0];
        end
        if (wr_idata) begin
            s_d.regs[s_q.idx] = wdata & reg_wmask(int'(s_q.idx));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.init <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign index_byte = {s_q.init, s_q.mce, s_q.trd, {(BYTE_W-3-IDX_W){1'b0}}, s_q.idx};
    assign cur_byte   = s_q.regs[s_q.idx];
    assign regs_flat  = s_q.regs;
    assign irq_en     = s_q.regs[IRQ_EN_REG][IRQ_EN_BIT];
    assign init_o     = s_q.init;
    assign mce_o      = s_q.mce;
    assign trd_o      = s_q.trd;

    // R4: after any index write, INIT is low for good
    a_r4_init_drop: assert property (@(posedge clk) disable iff (!rst_n)
        wr_index |=> !init_o);
    a_r4_init_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        !init_o |=> !init_o);
    // R2: an indexed write lands in the register selected before the write
    a_r2_idata_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_idata && !wr_index) |=> cur_byte == ($past(wdata) & reg_wmask(int'(s_q.idx))));

endmodule

// File: rtl/codec_status_unit.sv
module codec_status_unit
    import codec_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic              irq_event,
    input  logic              clr_int,
    input  logic              cap_valid,
    input  logic              cap_rd,
    input  logic              play_take,
    input  logic              play_wr,
    input  logic              flag_tick,
    input  logic [FLAG_W-1:0] flag_vec,
    output logic [BYTE_W-1:0] status_byte,
    output logic              irq
);
    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (flag_tick)              st_d.flags = flag_vec;
        if (cap_rd)                 st_d.crdy  = 1'b0;
        if (cap_valid)              st_d.crdy  = 1'b1;
        if (play_wr)                st_d.prdy  = 1'b0;
        if (play_take)              st_d.prdy  = 1'b1;
        if (clr_int)                st_d.intf  = 1'b0;
        if (irq_event && irq_en)    st_d.intf  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_byte = {st_q.flags[4], st_q.flags[3], st_q.crdy,
                          st_q.flags[2], st_q.flags[1], st_q.flags[0],
                          st_q.prdy, st_q.intf};
    assign irq = st_q.intf;

    // R8: sticky interrupt only cleared by a status write
    a_r8_int_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_int) |=> irq);
    a_r8_int_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(irq_event && irq_en)) |=> !irq);
    // R9: ready flags, set beats clear
    a_r9_crdy_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_rd && !cap_valid) |=> !status_byte[5]);
    a_r9_crdy_set: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> status_byte[5]);
    a_r9_prdy_set: assert property (@(posedge clk) disable iff (!rst_n)
        play_take |=> status_byte[1]);
    // R10: per-sample flags hold between ticks
    a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_tick |=> ($stable(status_byte[7:6]) && $stable(status_byte[4:2])));

endmodule

// File: rtl/codec_ctrl_port.sv
module codec_ctrl_port
    import codec_port_pkg::*;
#(
    parameter int NUM_REGS   = 16,
    parameter int IRQ_EN_REG = 10,
    parameter int IRQ_EN_BIT = 1,
    parameter int BASE_HI    = 14,
    parameter int BASE_LO    = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 host_addr,
    input  logic [7:0]                 host_wdata,
    input  logic                       host_rd,
    input  logic                       host_wr,
    output logic [7:0]                 host_rdata,
    input  logic                       cap_valid,
    input  logic [7:0]                 cap_byte,
    input  logic                       play_take,
    input  logic                       irq_event,
    input  logic                       flag_tick,
    input  logic [4:0]                 flag_vec,
    output logic [7:0]                 play_byte,
    output logic                       irq,
    output logic                       cfg_init,
    output logic                       cfg_mce,
    output logic                       cfg_trd,
    output logic [15:0]                base_count,
    output logic [NUM_REGS*8-1:0]      ctl_regs
);
    typedef struct packed {
        logic [BYTE_W-1:0] cap;
        logic [BYTE_W-1:0] play;
        logic [BYTE_W-1:0] rdata;
    } top_t;

    top_t t_d, t_q;

    port_e             sel;
    logic [BYTE_W-1:0] index_byte, cur_byte, status_byte;
    logic              irq_en;

    assign sel = port_e'(host_addr);

    codec_ireg_file #(
        .NUM_REGS  (NUM_REGS),
        .IRQ_EN_REG(IRQ_EN_REG),
        .IRQ_EN_BIT(IRQ_EN_BIT)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_index  (host_wr && sel == PORT_INDEX),
        .wr_idata  (host_wr && sel == PORT_IDATA),
        .wdata     (host_wdata),
        .index_byte(index_byte),
        .cur_byte  (cur_byte),
        .regs_flat (ctl_regs),
        .irq_en    (irq_en),
        .init_o    (cfg_init),
        .mce_o     (cfg_mce),
        .trd_o     (cfg_trd)
    );

    codec_status_unit u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_en     (irq_en),
        .irq_event  (irq_event),
        .clr_int    (host_wr && sel == PORT_STATUS),
        .cap_valid  (cap_valid),
        .cap_rd     (host_rd && sel == PORT_SAMPLE),
        .play_take  (play_take),
        .play_wr    (host_wr && sel == PORT_SAMPLE),
        .flag_tick  (flag_tick),
        .flag_vec   (flag_vec),
        .status_byte(status_byte),
        .irq        (irq)
    );

    always_comb begin
        t_d = t_q;
        if (cap_valid)                         t_d.cap  = cap_byte;
        if (host_wr && sel == PORT_SAMPLE)     t_d.play = host_wdata;
        if (host_rd) begin
            case (sel)
                PORT_INDEX:  t_d.rdata = index_byte;
                PORT_IDATA:  t_d.rdata = cur_byte;
                PORT_STATUS: t_d.rdata = status_byte;
                default:     t_d.rdata = t_q.cap;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign host_rdata = t_q.rdata;
    assign play_byte  = t_q.play;
    assign base_count = {ctl_regs[BASE_HI*8 +: 8], ctl_regs[BASE_LO*8 +: 8]};

    // R1: read data holds without a read strobe
    a_r1_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));
    // R6: playback byte only moves on a sample-port write; capture reads see the core byte
    a_r6_play_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && sel == PORT_SAMPLE) |=> $stable(play_byte));
    a_r6_cap_read: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid ##1 (host_rd && sel == PORT_SAMPLE && !cap_valid)) |=> host_rdata == $past(cap_byte, 2));

endmodule

// File: tb/tb_codec_ctrl_port.sv
`timescale 1ns/1ps
module tb_codec_ctrl_port;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   host_addr = '0;
    logic [7:0]   host_wdata = '0;
    logic         host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0]   host_rdata;
    logic         cap_valid = 1'b0;
    logic [7:0]   cap_byte = '0;
    logic         play_take = 1'b0, irq_event = 1'b0, flag_tick = 1'b0;
    logic [4:0]   flag_vec = '0;
    logic [7:0]   play_byte;
    logic         irq, cfg_init, cfg_mce, cfg_trd;
    logic [15:0]  base_count;
    logic [127:0] ctl_regs;

    always #2.5 clk = ~clk;

    codec_ctrl_port dut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
        .cap_valid(cap_valid), .cap_byte(cap_byte), .play_take(play_take),
        .irq_event(irq_event), .flag_tick(flag_tick), .flag_vec(flag_vec),
        .play_byte(play_byte), .irq(irq), .cfg_init(cfg_init), .cfg_mce(cfg_mce),
        .cfg_trd(cfg_trd), .base_count(base_count), .ctl_regs(ctl_regs)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [7:0] m_reg [16];
    logic [3:0] m_idx;
    logic       m_init, m_mce, m_trd, m_crdy, m_prdy, m_int;
    logic [7:0] m_cap, m_play, m_rdata;
    logic [4:0] m_flags;

    function automatic logic [7:0] exp_mask(input int n);
        if (n <= 1) return 8'hEF;
        if (n <= 5) return 8'h9F;
        if (n <= 7) return 8'hBF;
        if (n == 8) return 8'h7F;
        if (n == 9) return 8'hCF;
        if (n == 10) return 8'hC2;
        if (n == 12) return 8'h0F;
        if (n == 13) return 8'hFD;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] exp_status();
        return {m_flags[4], m_flags[3], m_crdy, m_flags[2], m_flags[1], m_flags[0], m_prdy, m_int};
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return {m_init, m_mce, m_trd, 1'b0, m_idx};
            2'd1: return m_reg[m_idx];
            2'd2: return exp_status();
            default: return m_cap;
        endcase
    endfunction

    task automatic mdl_reset();
        for (int i = 0; i < 16; i++) m_reg[i] = '0;
        m_idx = '0; m_init = 1'b1; m_mce = 1'b0; m_trd = 1'b0;
        m_crdy = 1'b0; m_prdy = 1'b0; m_int = 1'b0;
        m_cap = '0; m_play = '0; m_rdata = '0; m_flags = '0;
    endtask

    task automatic mdl_step();
        logic en_pre;
        en_pre = m_reg[10][1];
        if (host_rd) begin
            m_rdata = exp_read(host_addr);
            if (host_addr == 2'd3) m_crdy = 1'b0;
        end
        if (host_wr) begin
            case (host_addr)
                2'd0: begin m_init = 1'b0; m_mce = host_wdata[6]; m_trd = host_wdata[5]; m_idx = host_wdata[3:0]; end
                2'd1: m_reg[m_idx] = host_wdata & exp_mask(int'(m_idx));
                2'd2: m_int = 1'b0;
                default: begin m_play = host_wdata; m_prdy = 1'b0; end
            endcase
        end
        if (irq_event && en_pre) m_int = 1'b1;
        if (cap_valid) begin m_cap = cap_byte; m_crdy = 1'b1; end
        if (play_take) m_prdy = 1'b1;
        if (flag_tick) m_flags = flag_vec;
    endtask

    task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // one clock: inputs set at a falling edge, state updates at the rising edge,
    // results sampled at the following falling edge
    task automatic go();
        mdl_step();
        @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0; cap_valid = 1'b0; play_take = 1'b0;
        irq_event = 1'b0; flag_tick = 1'b0;
    endtask

    task automatic chk_outs();
        logic [127:0] flat;
        for (int i = 0; i < 16; i++) flat[i*8 +: 8] = m_reg[i];
        chk("R11 ctl_regs", ctl_regs, flat);
        chk("R11 base_count", {112'd0, base_count}, {112'd0, m_reg[14], m_reg[15]});
        chk("R6 play_byte", {120'd0, play_byte}, {120'd0, m_play});
        chk("R8 irq", {127'd0, irq}, {127'd0, m_int});
        chk("R3 cfg_mce/trd", {126'd0, cfg_mce, cfg_trd}, {126'd0, m_mce, m_trd});
        chk("R4 cfg_init", {127'd0, cfg_init}, {127'd0, m_init});
    endtask

    task automatic wr_op(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        go();
    endtask

    task automatic rd_op(input logic [1:0] a, input string tag);
        host_addr = a; host_rd = 1'b1;
        go();
        chk(tag, {120'd0, host_rdata}, {120'd0, m_rdata});
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] st;
        void'($urandom(32'h5EED));
        mdl_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 / R4: reset state
        chk_outs();
        rd_op(2'd0, "R12 R4 index after reset");
        rd_op(2'd2, "R12 status after reset");
        rd_op(2'd3, "R12 capture after reset");

        // R3 / R4: index write with every upper bit set
        wr_op(2'd0, 8'hFB);
        rd_op(2'd0, "R3 R4 index readback");
        chk_outs();

        // R5 / R2 / R11: all-ones into every register, then readback
        for (int i = 0; i < 16; i++) begin
            wr_op(2'd0, 8'(i));
            wr_op(2'd1, 8'hFF);
        end
        for (int i = 0; i < 16; i++) begin
            wr_op(2'd0, 8'(i));
            rd_op(2'd1, "R5 R2 masked readback");
        end
        chk_outs();
        wr_op(2'd0, 8'd14); wr_op(2'd1, 8'hA5);
        wr_op(2'd0, 8'd15); wr_op(2'd1, 8'h3C);
        chk("R11 base_count order", {112'd0, base_count}, {112'd0, 16'hA53C});

        // R6: sample port split
        wr_op(2'd3, 8'h5A);
        chk("R6 play_byte write", {120'd0, play_byte}, {120'd0, 8'h5A});
        rd_op(2'd3, "R6 capture unaffected by playback write");
        cap_valid = 1'b1; cap_byte = 8'hC3; go();
        rd_op(2'd3, "R6 capture byte read");

        // R8: interrupt gating and stickiness
        wr_op(2'd0, 8'd10); wr_op(2'd1, 8'h00);
        irq_event = 1'b1; go();
        chk("R8 gated off", {127'd0, irq}, {127'd0, 1'b0});
        wr_op(2'd1, 8'h02);
        irq_event = 1'b1; go();
        chk("R8 set when enabled", {127'd0, irq}, {127'd0, 1'b1});
        wr_op(2'd1, 8'h00);
        wr_op(2'd0, 8'h0A);
        wr_op(2'd3, 8'h11);
        chk("R8 sticky across other writes", {127'd0, irq}, {127'd0, 1'b1});
        rd_op(2'd2, "R7 R8 status with int");
        wr_op(2'd2, 8'h00);
        chk("R8 cleared by status write", {127'd0, irq}, {127'd0, 1'b0});
        wr_op(2'd1, 8'h02);
        irq_event = 1'b1; go();
        host_addr = 2'd2; host_wdata = 8'hFF; host_wr = 1'b1; irq_event = 1'b1; go();
        chk("R8 set beats clear", {127'd0, irq}, {127'd0, 1'b1});

        // R9: ready flags
        cap_valid = 1'b1; cap_byte = 8'h77; go();
        rd_op(2'd2, "R9 capture ready set");
        rd_op(2'd3, "R9 capture read");
        rd_op(2'd2, "R9 capture ready cleared");
        host_addr = 2'd3; host_rd = 1'b1; cap_valid = 1'b1; cap_byte = 8'h99; go();
        chk("R9 read returns old capture", {120'd0, host_rdata}, {120'd0, 8'h77});
        rd_op(2'd2, "R9 set beats read clear");
        play_take = 1'b1; go();
        rd_op(2'd2, "R9 playback ready set");
        host_addr = 2'd3; host_wdata = 8'h42; host_wr = 1'b1; play_take = 1'b1; go();
        rd_op(2'd2, "R9 playback set beats clear");
        wr_op(2'd3, 8'h43);
        rd_op(2'd2, "R9 playback ready cleared");

        // R10 / R7: flag placement
        flag_tick = 1'b1; flag_vec = 5'b10101; go();
        rd_op(2'd2, "R10 R7 flags 10101");
        flag_vec = 5'b01010; go();
        rd_op(2'd2, "R10 flags hold without tick");
        flag_tick = 1'b1; go();
        rd_op(2'd2, "R10 R7 flags 01010");
        chk_outs();

        // random mix
        for (int it = 0; it < 4000; it++) begin
            int op;
            op = int'($urandom % 8);
            host_addr = 2'($urandom % 4);
            host_wdata = 8'($urandom);
            if (host_addr == 2'd0 && ($urandom % 3 == 0)) host_wdata[3:0] = 4'd10;
            if (op < 3)      host_rd = 1'b1;
            else if (op < 6) host_wr = 1'b1;
            if ($urandom % 4 == 0) begin cap_valid = 1'b1; cap_byte = 8'($urandom); end
            if ($urandom % 4 == 0) play_take = 1'b1;
            if ($urandom % 3 == 0) irq_event = 1'b1;
            if ($urandom % 5 == 0) begin flag_tick = 1'b1; flag_vec = 5'($urandom); end
            st = host_rd ? {6'd0, host_addr} : 8'hFF;
            go();
            if (st != 8'hFF) begin
                case (st[1:0])
                    2'd0: chk("R1 R3 random index read", {120'd0, host_rdata}, {120'd0, m_rdata});
                    2'd1: chk("R1 R2 random indexed read", {120'd0, host_rdata}, {120'd0, m_rdata});
                    2'd2: chk("R1 R7 random status read", {120'd0, host_rdata}, {120'd0, m_rdata});
                    default: chk("R1 R6 random capture read", {120'd0, host_rdata}, {120'd0, m_rdata});
                endcase
            end
            if (it % 50 == 0) chk_outs();
        end
        chk_outs();

        summary();
        $finish;
    end

endmodule